// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block classifies every physical memory access against the legacy map that sits between 640 KB and 1 MB, plus a programmable top-of-memory (TOM) limit. The window holds three display-memory windows of uneven size and sixteen equal 16 KB segments for option and system ROM. Each of these nineteen regions carries its own permission bits. For each access the block returns the permissions and routing of the region that the access falls in. It also returns the address after bit 20 has been gated.

Address bit 20 can be cleared to give the wrap-around that old real-mode software expects. This gating is skipped for accesses made in system-management mode. The gated address is the one that gets decoded, so a wrapped access picks up the attributes of its low-memory alias. A simple write port programs the region bits, the TOM limit and the wrap control. All decode results are registered and appear in the cycle after the access strobe.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset, all nineteen region attribute sets are zero (no read, write, cache or master access, and no graphics routing). The wrap mask is clear, the TOM limit equals the parameter TOM_RESET (default 0x0100_0000), and dec_valid is low.
- R2: When acc_valid is sampled high at a clock edge, dec_valid is high after that edge and the decode outputs describe that access. When acc_valid is low, dec_valid is low after the edge.
- R3: dec_addr equals acc_addr with bit 20 forced to zero when the wrap mask is set and acc_smm is low. In every other case dec_addr equals acc_addr unchanged.
- R4: The region lookup uses the gated address, so a masked access to 0x1A0000–0x1FFFFF returns the attributes of 0x0A0000–0x0FFFFF.
- R5: The display windows are region 0 = 0xA0000–0xAFFFF, region 1 = 0xB0000–0xB7FFF and region 2 = 0xB8000–0xBFFFF.
- R6: Region 3+k covers 0xC0000 + k·0x4000 through the following 0x3FFF bytes, for k = 0 to 15.
- R7: An attribute word written to a region selects the permissions in this way: bit 0 = read allowed, bit 1 = write allowed, bit 2 = cacheable, bit 3 = external bus master allowed. Inside the window, the outputs dec_rd_ok, dec_wr_ok, dec_cache_ok and dec_master_ok take exactly these bits of the matched region.
- R8: Attribute bit 4 routes accesses to the graphics pipeline (dec_to_gfx) in regions 0 to 2 only. The same bit written to regions 3 to 18 has no effect.
- R9: An address outside 0xA0000–0xFFFFF and below TOM gets all four permissions set, with dec_to_gfx and dec_above_tom low.
- R10: An address outside the window and at or above TOM sets dec_above_tom, and all permissions and the routing are low.
- R11: dec_access_ok equals write permission for writes and read permission for reads. For an access by an external bus master it also requires the master permission.
- R12: Configuration select values work as follows: 0–18 address a region (data bits 4:0), 19 loads TOM from the data bus, and 20 loads the wrap mask from data bit 21. A write with any other select value changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_smm | input | 1 | Access made in system-management mode |
| acc_ext_master | input | 1 | Access comes from an external bus master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration target select |
| cfg_wdata | input | CFG_W | Configuration write data |
| dec_valid | output | 1 | Registered decode is valid |
| dec_addr | output | ADDR_W | Address after bit-20 gating |
| dec_rd_ok | output | 1 | Read allowed |
| dec_wr_ok | output | 1 | Write allowed |
| dec_cache_ok | output | 1 | Cacheable |
| dec_master_ok | output | 1 | External bus master allowed |
| dec_to_gfx | output | 1 | Route to graphics pipeline |
| dec_above_tom | output | 1 | Address at or above top of memory |
| dec_access_ok | output | 1 | This access is permitted |

## Verification
The properties assume that the configuration state is not written in the same cycle as an access whose result depends on the new value. Under that assumption, the value seen by the access is the one held before the edge. The stimulus drives each configuration write in a cycle of its own and leaves a gap cycle before the next access, so every decode sees settled state. Random addresses are biased toward the legacy window, its bit-20 aliases, the TOM boundary and the rest of the 32-bit space.

// File: rtl/lrd_pkg.sv
`timescale 1ns/1ps
package lrd_pkg;
   localparam int NUM_VGA     = 3;
   localparam int NUM_ROM     = 16;
   localparam int NUM_REGIONS = NUM_VGA + NUM_ROM;
   localparam int SEL_W       = 5;
   localparam int IDX_W       = $clog2(NUM_REGIONS);
   localparam int SEL_TOM     = NUM_REGIONS;
   localparam int SEL_CTRL    = NUM_REGIONS + 1;
   localparam int A20_CTRL_BIT = 21;
   localparam int WRAP_BIT    = 20;

   localparam logic [19:0] VGA0_LO = 20'hA0000;
   localparam logic [19:0] VGA1_LO = 20'hB0000;
   localparam logic [19:0] VGA2_LO = 20'hB8000;
   localparam logic [19:0] ROM_LO  = 20'hC0000;

   typedef struct packed {
      logic gfx;
      logic master;
      logic cache;
      logic wr;
      logic rd;
   } region_attr_t;

   localparam int ATTR_W = $bits(region_attr_t);
endpackage

// File: rtl/lrd_a20_gate.sv
`timescale 1ns/1ps
module lrd_a20_gate #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              smm,
   input  logic              wrap_mask,
   output logic [ADDR_W-1:0] addr_out
);
   localparam logic [ADDR_W-1:0] CLR = ~(ADDR_W'(1) << lrd_pkg::WRAP_BIT);

   always_comb begin
      if (wrap_mask && !smm) addr_out = addr_in & CLR;
      else                   addr_out = addr_in;
   end
endmodule

// File: rtl/lrd_region_match.sv
`timescale 1ns/1ps
module lrd_region_match #(
   parameter int ADDR_W    = 32,
   parameter int SEG_BYTES = 16384
) (
   input  logic [ADDR_W-1:0]          addr,
   output logic                       hit,
   output logic [lrd_pkg::IDX_W-1:0]  idx
);
   import lrd_pkg::*;

   localparam int ROM_SPAN = NUM_ROM * SEG_BYTES;

   if (ROM_SPAN != 32'h40000) begin : g_bad_span
      $error("ROM segments must tile 0xC0000-0xFFFFF exactly");
   end

   logic        low_mb;
   logic [19:0] off;
   logic [NUM_REGIONS-1:0] match;

   assign low_mb = ((addr >> 20) == '0);
   assign off    = addr[19:0];

   assign match[0] = low_mb && (off >= VGA0_LO) && (off < VGA1_LO);
   assign match[1] = low_mb && (off >= VGA1_LO) && (off < VGA2_LO);
   assign match[2] = low_mb && (off >= VGA2_LO) && (off < ROM_LO);

   for (genvar k = 0; k < NUM_ROM; k++) begin : g_rom
      localparam logic [20:0] BASE = 21'(ROM_LO) + 21'(k * SEG_BYTES);
      localparam logic [20:0] LIM  = BASE + 21'(SEG_BYTES);
      assign match[NUM_VGA + k] = low_mb && ({1'b0, off} >= BASE) && ({1'b0, off} < LIM);
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (match[r] && !hit) begin
            hit = 1'b1;
            idx = IDX_W'(r);
         end
      end
   end
endmodule

// File: rtl/lrd_attr_bank.sv
`timescale 1ns/1ps
module lrd_attr_bank #(
   parameter int CFG_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [lrd_pkg::SEL_W-1:0]   cfg_sel,
   input  logic [CFG_W-1:0]            cfg_wdata,
   input  logic [lrd_pkg::IDX_W-1:0]   rd_idx,
   output lrd_pkg::region_attr_t       rd_attr
);
   import lrd_pkg::*;

   region_attr_t regs [NUM_REGIONS];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
      region_attr_t nxt;
      always_comb begin
         nxt = region_attr_t'(cfg_wdata[ATTR_W-1:0]);
         if (r >= NUM_VGA) nxt.gfx = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) regs[r] <= '0;
         else if (cfg_we && cfg_sel == SEL_W'(r)) regs[r] <= nxt;
      end
   end

   always_comb begin
      rd_attr = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (rd_idx == IDX_W'(r)) rd_attr = regs[r];
      end
   end
endmodule

// File: rtl/legacy_region_decoder.sv
`timescale 1ns/1ps
module legacy_region_decoder #(
   parameter int              ADDR_W    = 32,
   parameter int              CFG_W     = 32,
   parameter int              SEG_BYTES = 16384,
   parameter longint unsigned TOM_RESET = 64'h0100_0000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic                      acc_write,
   input  logic                      acc_smm,
   input  logic                      acc_ext_master,
   input  logic                      cfg_we,
   input  logic [4:0]                cfg_sel,
   input  logic [CFG_W-1:0]          cfg_wdata,
   output logic                      dec_valid,
   output logic [ADDR_W-1:0]         dec_addr,
   output logic                      dec_rd_ok,
   output logic                      dec_wr_ok,
   output logic                      dec_cache_ok,
   output logic                      dec_master_ok,
   output logic                      dec_to_gfx,
   output logic                      dec_above_tom,
   output logic                      dec_access_ok
);
   import lrd_pkg::*;

   if (ADDR_W < 21) begin : g_bad_addr
      $error("ADDR_W must reach bit 20");
   end
   if (CFG_W < ADDR_W || CFG_W <= A20_CTRL_BIT) begin : g_bad_cfg
      $error("CFG_W must hold a full address and the wrap control bit");
   end

   logic [ADDR_W-1:0] tom_q;
   logic              a20_mask_q;
   logic [ADDR_W-1:0] gated;
   logic              hit;
   logic [IDX_W-1:0]  idx;
   region_attr_t      attr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tom_q      <= ADDR_W'(TOM_RESET);
         a20_mask_q <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_W'(SEL_TOM))  tom_q      <= cfg_wdata[ADDR_W-1:0];
         if (cfg_sel == SEL_W'(SEL_CTRL)) a20_mask_q <= cfg_wdata[A20_CTRL_BIT];
      end
   end

   lrd_a20_gate #(.ADDR_W(ADDR_W)) u_gate (
      .addr_in(acc_addr), .smm(acc_smm), .wrap_mask(a20_mask_q), .addr_out(gated)
   );

   lrd_region_match #(.ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_match (
      .addr(gated), .hit(hit), .idx(idx)
   );

   lrd_attr_bank #(.CFG_W(CFG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rd_idx(idx), .rd_attr(attr)
   );

   region_attr_t res;
   logic         above, ok;

   always_comb begin
      above = 1'b0;
      if (hit) begin
         res = attr;
      end else if (gated >= tom_q) begin
         res   = '0;
         above = 1'b1;
      end else begin
         res     = '1;
         res.gfx = 1'b0;
      end
      ok = acc_write ? res.wr : res.rd;
      if (acc_ext_master) ok = ok && res.master;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid     <= 1'b0;
         dec_addr      <= '0;
         dec_rd_ok     <= 1'b0;
         dec_wr_ok     <= 1'b0;
         dec_cache_ok  <= 1'b0;
         dec_master_ok <= 1'b0;
         dec_to_gfx    <= 1'b0;
         dec_above_tom <= 1'b0;
         dec_access_ok <= 1'b0;
      end else begin
         dec_valid <= acc_valid;
         if (acc_valid) begin
            dec_addr      <= gated;
            dec_rd_ok     <= res.rd;
            dec_wr_ok     <= res.wr;
            dec_cache_ok  <= res.cache;
            dec_master_ok <= res.master;
            dec_to_gfx    <= res.gfx;
            dec_above_tom <= above;
            dec_access_ok <= ok;
         end
      end
   end
endmodule

// File: rtl/lrd_checker.sv
`timescale 1ns/1ps
module lrd_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              acc_smm,
   input logic              acc_ext_master,
   input logic              a20_mask_q,
   input logic              dec_valid,
   input logic [ADDR_W-1:0] dec_addr,
   input logic              dec_rd_ok,
   input logic              dec_wr_ok,
   input logic              dec_cache_ok,
   input logic              dec_master_ok,
   input logic              dec_to_gfx,
   input logic              dec_above_tom,
   input logic              dec_access_ok
);
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> dec_valid);
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !dec_valid);
   a_r3_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && a20_mask_q && !acc_smm |=> !dec_addr[20]);
   a_r3_smm_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_smm |=> dec_addr == $past(acc_addr));
   a_r10_above_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_above_tom |->
         !(dec_rd_ok || dec_wr_ok || dec_cache_ok || dec_master_ok || dec_to_gfx));
   a_r8_gfx_window: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_to_gfx |-> (dec_addr >> 17) == ADDR_W'(5));
   a_r11_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_write && !acc_ext_master |=> dec_access_ok == dec_rd_ok);
   a_r11_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_write |=> !dec_access_ok || dec_wr_ok);
   a_r11_master_ok: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ext_master |=> !dec_access_ok || dec_master_ok);
endmodule

bind legacy_region_decoder lrd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
   .acc_write(acc_write), .acc_smm(acc_smm), .acc_ext_master(acc_ext_master),
   .a20_mask_q(a20_mask_q), .dec_valid(dec_valid), .dec_addr(dec_addr),
   .dec_rd_ok(dec_rd_ok), .dec_wr_ok(dec_wr_ok), .dec_cache_ok(dec_cache_ok),
   .dec_master_ok(dec_master_ok), .dec_to_gfx(dec_to_gfx),
   .dec_above_tom(dec_above_tom), .dec_access_ok(dec_access_ok)
);

// File: tb/legacy_region_decoder_tb.sv
`timescale 1ns/1ps
module legacy_region_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0, acc_smm = 1'b0, acc_ext_master = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        dec_valid, dec_rd_ok, dec_wr_ok, dec_cache_ok, dec_master_ok;
   logic        dec_to_gfx, dec_above_tom, dec_access_ok;
   logic [31:0] dec_addr;

   int checks = 0;
   int fails  = 0;

   logic [4:0]  m_attr [19];
   logic [31:0] m_tom;
   logic        m_mask;

   always #10 clk = ~clk;

   legacy_region_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_smm(acc_smm), .acc_ext_master(acc_ext_master),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_rd_ok(dec_rd_ok),
      .dec_wr_ok(dec_wr_ok), .dec_cache_ok(dec_cache_ok), .dec_master_ok(dec_master_ok),
      .dec_to_gfx(dec_to_gfx), .dec_above_tom(dec_above_tom), .dec_access_ok(dec_access_ok)
   );

   task automatic check(input bit cond, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int region_of(input logic [31:0] a);
      if (a[31:20] != 0 || a[19:0] < 20'hA0000) return -1;
      if (a[19:0] < 20'hB0000) return 0;
      if (a[19:0] < 20'hB8000) return 1;
      if (a[19:0] < 20'hC0000) return 2;
      return 3 + int'((a[19:0] - 20'hC0000) >> 14);
   endfunction

   task automatic cfg_write(input logic [4:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 19)       m_attr[sel] = data[4:0];
      else if (sel == 19) m_tom = data;
      else if (sel == 20) m_mask = data[21];
   endtask

   task automatic access(input logic [31:0] a, input bit wr, input bit smm,
                         input bit mst, input string req);
      logic [31:0] g;
      logic [4:0]  e;
      int          r;
      bit          above, ok;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_smm = smm; acc_ext_master = mst;
      @(negedge clk);
      acc_valid = 1'b0;
      g = (m_mask && !smm) ? (a & ~32'h0010_0000) : a;
      r = region_of(g);
      above = 1'b0;
      if (r >= 0) begin
         e = m_attr[r];
         if (r >= 3) e[4] = 1'b0;
      end else if (g >= m_tom) begin
         e = 5'b0; above = 1'b1;
      end else e = 5'b01111;
      ok = wr ? e[1] : e[0];
      if (mst) ok = ok && e[3];
      check(dec_valid == 1'b1, "R2", 32'(dec_valid), 32'd1);
      check(dec_addr == g, "R3", dec_addr, g);
      check({dec_master_ok, dec_cache_ok, dec_wr_ok, dec_rd_ok} == e[3:0], req,
            {28'd0, dec_master_ok, dec_cache_ok, dec_wr_ok, dec_rd_ok}, {28'd0, e[3:0]});
      check(dec_to_gfx == e[4], "R8", 32'(dec_to_gfx), 32'(e[4]));
      check(dec_above_tom == above, "R10", 32'(dec_above_tom), 32'(above));
      check(dec_access_ok == ok, "R11", 32'(dec_access_ok), 32'(ok));
   endtask

   function automatic string class_req(input logic [31:0] a, input bit smm);
      logic [31:0] g;
      g = (m_mask && !smm) ? (a & ~32'h0010_0000) : a;
      if (region_of(g) >= 0) return "R7";
      if (g >= m_tom) return "R10";
      return "R9";
   endfunction

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] a, d;
      void'($urandom(32'd1234));
      for (int i = 0; i < 19; i++) m_attr[i] = 5'b0;
      m_tom = 32'h0100_0000; m_mask = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_valid == 1'b0, "R1", 32'(dec_valid), 32'd0);
      // R1: reset attributes zero, TOM at default
      access(32'h000A_1000, 1'b0, 1'b0, 1'b0, "R1");
      access(32'h000F_FFFF, 1'b1, 1'b0, 1'b0, "R1");
      access(32'h00FF_FFFF, 1'b0, 1'b0, 1'b0, "R9");
      access(32'h0100_0000, 1'b0, 1'b0, 1'b0, "R10");
      @(negedge clk);
      check(dec_valid == 1'b0, "R2", 32'(dec_valid), 32'd0);
      // R5: distinct attributes per display window, edges of each
      cfg_write(5'd0, 32'h11);
      cfg_write(5'd1, 32'h12);
      cfg_write(5'd2, 32'h1C);
      access(32'h000A_FFFF, 1'b0, 1'b0, 1'b0, "R5");
      access(32'h000B_0000, 1'b1, 1'b0, 1'b0, "R5");
      access(32'h000B_7FFF, 1'b1, 1'b0, 1'b0, "R5");
      access(32'h000B_8000, 1'b0, 1'b0, 1'b1, "R5");
      // R6 / R8: segments get their index, graphics bit ignored there
      for (int k = 0; k < 16; k++) cfg_write(5'(3 + k), 32'h10 | 32'(k & 15));
      for (int k = 0; k < 16; k++) begin
         access(32'h000C_0000 + 32'(k) * 32'h4000, 1'b0, 1'b0, 1'b0, "R6");
         access(32'h000C_3FFF + 32'(k) * 32'h4000, 1'b1, 1'b0, 1'b1, "R6");
      end
      // R12: TOM and wrap mask, invalid selects ignored
      cfg_write(5'd19, 32'h0040_0000);
      access(32'h003F_FFFF, 1'b0, 1'b0, 1'b0, "R12");
      access(32'h0040_0000, 1'b0, 1'b0, 1'b0, "R12");
      cfg_write(5'd21, 32'hFFFF_FFFF);
      cfg_write(5'd31, 32'h0000_0000);
      access(32'h0040_0000, 1'b0, 1'b0, 1'b0, "R12");
      access(32'h000A_0000, 1'b0, 1'b0, 1'b0, "R12");
      cfg_write(5'd20, 32'h0020_0000);
      // R4: wrapped alias decodes as low memory; SMM bypasses gating
      access(32'h001A_0000, 1'b0, 1'b0, 1'b0, "R4");
      access(32'h001C_4000, 1'b1, 1'b0, 1'b0, "R4");
      access(32'h001A_0000, 1'b0, 1'b1, 1'b0, "R3");
      // constrained random
      for (int n = 0; n < 1500; n++) begin
         if (($urandom % 8) == 0) begin
            int s;
            s = $urandom % 24;
            d = $urandom;
            if (s == 19) d = (d & 32'h01FF_FFFF) | 32'h0010_0000;
            cfg_write(5'(s), d);
         end
         case ($urandom % 5)
            0: a = 32'h000A_0000 + ($urandom % 32'h6_0000);
            1: a = 32'h001A_0000 + ($urandom % 32'h6_0000);
            2: a = $urandom % 32'h000A_0000;
            3: a = m_tom + ($urandom % 5) - 2;
            default: a = $urandom;
         endcase
         begin
            bit wr, smm, mst;
            wr = 1'($urandom); smm = (($urandom % 4) == 0); mst = 1'($urandom);
            access(a, wr, smm, mst, class_req(a, smm));
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule